// File: doc/BRIEF.md
# I/O Window Bus Target

This block is the responding side of a 32-bit multiplexed address/data bus. It watches each address phase and claims two kinds of access. The first kind is an I/O read or write that falls inside a 256-byte window. The window is set by a base register held inside the block. The second kind is a configuration read or write aimed at this device by its select line. Every bus signal comes as a separate input, output and output-enable, so the pad ring can build the tri-state buffers.

Claimed I/O accesses are handed to a back-end device through an active-low pair. The block pulls `be_ack_n_o` low once the address, write data and byte enables are valid. The back-end answers by pulling `be_req_n_i` low when it is done. The block never bursts. The single data phase of each access is finished with ready and stop together. If the initiator still holds frame after that phase, the block waits in a hold-off state until frame rises. One release cycle then drives the control lines high before letting go of them. The block answers configuration accesses itself: it returns a fixed identity word, reads and writes the window base, and returns zero for every other register.

Top module: `iop_target`

## Requirements
- R1: After reset, `ctl_oe_o` and `ad_oe_o` are 0, `trdy_n_o`, `stop_n_o`, `devsel_n_o` and `be_ack_n_o` are 1, `be_cfg_o` is 0, and a configuration read of register index 4 (byte offset 10h) returns 32'h0000_0001.
- R2: An I/O access is started when `frame_n_i` is low and `cbe_n_i` is 4'b0010 (read) or 4'b0011 (write). If `ad_i[31:8]` equals bits 31:8 of the base register, `devsel_n_o` falls at the second rising edge after the address phase, with `ctl_oe_o` high.
- R3: An I/O address outside the window, any other command, and any address phase seen while another access keeps frame low leave `devsel_n_o` and `be_ack_n_o` high. The block accepts a new address phase only after frame has been high.
- R4: In the data phase of a claimed I/O access, `be_ack_n_o` falls on the edge after `irdy_n_i` is seen low. At the same time `be_addr_o`, `be_data_o` (the write data), `be_ben_o` and `be_read_o` (1 for a read) are valid. `trdy_n_o` stays high for as long as `be_req_n_i` stays high.
- R5: On the edge after `be_req_n_i` is seen low with the acknowledge asserted, `trdy_n_o` and `stop_n_o` fall together. For a read, `ad_o` carries `be_rdata_i` and `ad_oe_o` is 1.
- R6: The data phase ends at an edge where both `trdy_n_o` and `irdy_n_i` are low. If frame is still low at that edge, `trdy_n_o` and `be_ack_n_o` rise while `stop_n_o` and `devsel_n_o` stay low until the edge after frame is seen high.
- R7: The release cycle drives `trdy_n_o`, `stop_n_o` and `devsel_n_o` high with `ctl_oe_o` high for exactly one clock. `ctl_oe_o` is 0 after it.
- R8: A configuration access needs `frame_n_i` low, `idsel_i` high, `cbe_n_i` of 4'b1010 (read) or 4'b1011 (write), and `ad_i[1:0]` of 00. The register index is `ad_i[7:2]`. `devsel_n_o` falls and `be_cfg_o` rises on the first edge after the address phase. Ready and stop follow one edge later. `be_ack_n_o` stays high throughout.
- R9: A configuration read returns {DEV_ID, VEN_ID} at index 0 and the base register at index 4. It returns 0 at every other index.
- R10: A configuration write to index 4 replaces each byte k of the base for which `cbe_n_i[k]` is 0. Bits 7:0 always read 8'h01. A write to any other index changes nothing.
- R11: `ad_oe_o` is 1 only while the block presents read data with `trdy_n_o` low. For writes it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n_i | input | 1 | Frame from the initiator, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| idsel_i | input | 1 | Configuration select |
| ad_i | input | 32 | Address/data bus input |
| cbe_n_i | input | 4 | Command / byte enables, active low enables |
| ad_o | output | 32 | Read data driven onto the bus |
| ad_oe_o | output | 1 | Enable for `ad_o` |
| trdy_n_o | output | 1 | Target ready, active low |
| stop_n_o | output | 1 | Stop, active low |
| devsel_n_o | output | 1 | Device select, active low |
| ctl_oe_o | output | 1 | Enable for trdy, stop and devsel |
| be_addr_o | output | 32 | Latched access address to the back-end |
| be_data_o | output | 32 | Latched write data to the back-end |
| be_ben_o | output | 4 | Latched byte enables, active low |
| be_read_o | output | 1 | 1 for a read access |
| be_cfg_o | output | 1 | Configuration access in progress |
| be_ack_n_o | output | 1 | Access pending, active low |
| be_req_n_i | input | 1 | Back-end done, active low |
| be_rdata_i | input | 32 | Back-end read data |

## Verification
Two events can land on the same clock edge: the end of the single data phase, and the initiator raising frame. When they meet, the block must go straight to the release cycle. When frame is still low, it must instead hold stop and device-select in hold-off. The bench provokes both cases by alternating a burst-attempt flag across the I/O sweep. It judges each case by the levels of stop and device-select on the following cycles. Configuration writes to the base register commit on the same edge that completes their data phase. The bench sweeps all sixteen byte-enable patterns and reads each result back through a later configuration read.

// File: rtl/iop_pkg.sv
package iop_pkg;

  localparam int AD_W  = 32;
  localparam int BEN_W = AD_W / 8;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_XFER,
    ST_HOLDOFF,
    ST_RELEASE,
    ST_OTHER,
    ST_CFG_RD,
    ST_CFG_WR
  } seq_state_e;

  // mask of the hard-wired low bits of the window base
  function automatic logic [AD_W-1:0] win_mask(input int win_bits);
    return (AD_W'(1) << win_bits) - AD_W'(1);
  endfunction

  // address lies inside the window selected by base
  function automatic logic win_hit(input logic [AD_W-1:0] addr,
                                   input logic [AD_W-1:0] base,
                                   input int win_bits);
    return ((addr ^ base) & ~win_mask(win_bits)) == '0;
  endfunction

  // byte-enabled update of the base, low bits forced to the I/O marker
  function automatic logic [AD_W-1:0] base_merge(input logic [AD_W-1:0] old,
                                                 input logic [AD_W-1:0] wdata,
                                                 input logic [BEN_W-1:0] ben_n,
                                                 input int win_bits);
    logic [AD_W-1:0] r;
    r = old;
    for (int b = 0; b < BEN_W; b++) begin
      if (!ben_n[b]) r[b*8 +: 8] = wdata[b*8 +: 8];
    end
    return (r & ~win_mask(win_bits)) | AD_W'(1);
  endfunction

endpackage

// File: rtl/iop_decode.sv
module iop_decode
  import iop_pkg::*;
(
  input  logic       frame_n_i,
  input  logic       idsel_i,
  input  logic [3:0] cbe_n_i,
  input  logic [1:0] ad_lo_i,
  output logic       io_start_o,
  output logic       io_rd_o,
  output logic       cfg_start_o,
  output logic       cfg_rd_o
);

  logic is_io, is_cfg;

  always_comb begin
    is_io       = (cbe_n_i == CMD_IO_RD) || (cbe_n_i == CMD_IO_WR);
    is_cfg      = (cbe_n_i == CMD_CFG_RD) || (cbe_n_i == CMD_CFG_WR);
    io_start_o  = !frame_n_i && is_io;
    io_rd_o     = (cbe_n_i == CMD_IO_RD);
    cfg_start_o = !frame_n_i && idsel_i && is_cfg && (ad_lo_i == 2'b00);
    cfg_rd_o    = (cbe_n_i == CMD_CFG_RD);
  end

endmodule

// File: rtl/iop_window.sv
module iop_window
  import iop_pkg::*;
#(
  parameter int          WIN_BITS = 8,
  parameter logic [5:0]  BAR_IDX  = 6'd4,
  parameter logic [5:0]  ID_IDX   = 6'd0,
  parameter logic [15:0] VEN_ID   = 16'h5A17,
  parameter logic [15:0] DEV_ID   = 16'hC0DE
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  addr_i,
  input  logic [5:0]       ofs_i,
  input  logic             wr_en_i,
  input  logic [AD_W-1:0]  wdata_i,
  input  logic [BEN_W-1:0] wben_n_i,
  output logic             hit_o,
  output logic [AD_W-1:0]  cfg_rdata_o
);

  localparam logic [AD_W-1:0] BASE_RST = base_merge('0, '0, '1, WIN_BITS);

  logic [AD_W-1:0] bar_q;
  logic            bar_write;

  assign bar_write = wr_en_i && (ofs_i == BAR_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bar_q <= BASE_RST;
    else if (bar_write) bar_q <= base_merge(bar_q, wdata_i, wben_n_i, WIN_BITS);
  end

  assign hit_o = win_hit(addr_i, bar_q, WIN_BITS);

  always_comb begin
    if (ofs_i == ID_IDX)       cfg_rdata_o = {DEV_ID, VEN_ID};
    else if (ofs_i == BAR_IDX) cfg_rdata_o = bar_q;
    else                       cfg_rdata_o = '0;
  end

  // R10
  bar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && ofs_i == BAR_IDX) |=> $stable(bar_q));

endmodule

// File: rtl/iop_seq.sv
module iop_seq
  import iop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [BEN_W-1:0] cbe_n_i,
  input  logic             io_start_i,
  input  logic             io_rd_i,
  input  logic             cfg_start_i,
  input  logic             cfg_rd_i,
  input  logic             hit_i,
  input  logic [AD_W-1:0]  cfg_rdata_i,
  input  logic             be_req_n_i,
  input  logic [AD_W-1:0]  be_rdata_i,
  output logic [AD_W-1:0]  ad_o,
  output logic             ad_oe_o,
  output logic             trdy_n_o,
  output logic             stop_n_o,
  output logic             devsel_n_o,
  output logic             ctl_oe_o,
  output logic [AD_W-1:0]  be_addr_o,
  output logic [AD_W-1:0]  be_data_o,
  output logic [BEN_W-1:0] be_ben_o,
  output logic             be_read_o,
  output logic             be_cfg_o,
  output logic             be_ack_n_o,
  output logic [5:0]       cfg_ofs_o,
  output logic             cfg_wr_done_o
);

  seq_state_e      state_q;
  logic [AD_W-1:0] addr_q, data_q, ad_q;
  logic [BEN_W-1:0] ben_q;
  logic            rd_q, ad_oe_q, trdy_n_q, stop_n_q, devsel_n_q, oe_q, ack_n_q;

  // named internal events
  logic phase_done;   // data phase completes this edge
  logic in_cfg;
  logic ack_take;     // back-end acknowledge begins
  logic req_seen;     // back-end finished

  assign phase_done    = !trdy_n_q && !irdy_n_i;
  assign in_cfg        = (state_q == ST_CFG_RD) || (state_q == ST_CFG_WR);
  assign ack_take      = (state_q == ST_XFER) && trdy_n_q && ack_n_q && !irdy_n_i;
  assign req_seen      = (state_q == ST_XFER) && trdy_n_q && !ack_n_q && !be_req_n_i;
  assign cfg_wr_done_o = (state_q == ST_CFG_WR) && phase_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      data_q     <= '0;
      ad_q       <= '0;
      ben_q      <= '1;
      rd_q       <= 1'b0;
      ad_oe_q    <= 1'b0;
      trdy_n_q   <= 1'b1;
      stop_n_q   <= 1'b1;
      devsel_n_q <= 1'b1;
      oe_q       <= 1'b0;
      ack_n_q    <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (io_start_i) begin
            addr_q  <= ad_i;
            rd_q    <= io_rd_i;
            state_q <= ST_COMPARE;
          end else if (cfg_start_i) begin
            addr_q     <= ad_i;
            rd_q       <= cfg_rd_i;
            devsel_n_q <= 1'b0;
            oe_q       <= 1'b1;
            state_q    <= cfg_rd_i ? ST_CFG_RD : ST_CFG_WR;
          end else if (!frame_n_i) begin
            state_q <= ST_OTHER;
          end
        end
        ST_COMPARE: begin
          if (hit_i) begin
            devsel_n_q <= 1'b0;
            oe_q       <= 1'b1;
            state_q    <= ST_XFER;
          end else begin
            state_q <= ST_OTHER;
          end
        end
        ST_OTHER: begin
          if (frame_n_i) state_q <= ST_IDLE;
        end
        ST_XFER, ST_CFG_RD, ST_CFG_WR: begin
          if (phase_done) begin
            ack_n_q  <= 1'b1;
            trdy_n_q <= 1'b1;
            ad_oe_q  <= 1'b0;
            if (frame_n_i) begin
              stop_n_q   <= 1'b1;
              devsel_n_q <= 1'b1;
              state_q    <= ST_RELEASE;
            end else begin
              state_q <= ST_HOLDOFF;
            end
          end else if (in_cfg) begin
            if (trdy_n_q) begin
              trdy_n_q <= 1'b0;
              stop_n_q <= 1'b0;
              if (state_q == ST_CFG_RD) begin
                ad_q    <= cfg_rdata_i;
                ad_oe_q <= 1'b1;
              end
            end
          end else if (ack_take) begin
            ack_n_q <= 1'b0;
            data_q  <= ad_i;
            ben_q   <= cbe_n_i;
          end else if (req_seen) begin
            trdy_n_q <= 1'b0;
            stop_n_q <= 1'b0;
            if (rd_q) begin
              ad_q    <= be_rdata_i;
              ad_oe_q <= 1'b1;
            end
          end
        end
        ST_HOLDOFF: begin
          if (frame_n_i) begin
            stop_n_q   <= 1'b1;
            devsel_n_q <= 1'b1;
            state_q    <= ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          oe_q    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ad_o       = ad_q;
  assign ad_oe_o    = ad_oe_q;
  assign trdy_n_o   = trdy_n_q;
  assign stop_n_o   = stop_n_q;
  assign devsel_n_o = devsel_n_q;
  assign ctl_oe_o   = oe_q;
  assign be_addr_o  = addr_q;
  assign be_data_o  = data_q;
  assign be_ben_o   = ben_q;
  assign be_read_o  = rd_q;
  assign be_cfg_o   = in_cfg;
  assign be_ack_n_o = ack_n_q;
  assign cfg_ofs_o  = addr_q[7:2];

  // R5
  ready_stop_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n_o) |-> !stop_n_o);

  // R4
  ack_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(trdy_n_o) && !be_cfg_o) |-> !be_ack_n_o);

  // R7
  release_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe_o && trdy_n_o && stop_n_o && devsel_n_o) |=> !ctl_oe_o);

  // R11
  ad_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> (!trdy_n_o && ctl_oe_o));

  // R8
  cfg_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_cfg_o |-> be_ack_n_o);

  // R3
  claim_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n_o) |-> ($past(hit_i) || be_cfg_o));

endmodule

// File: rtl/iop_target.sv
module iop_target
  import iop_pkg::*;
#(
  parameter int          WIN_BITS = 8,
  parameter logic [15:0] VEN_ID   = 16'h5A17,
  parameter logic [15:0] DEV_ID   = 16'hC0DE
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n_i,
  input  logic        irdy_n_i,
  input  logic        idsel_i,
  input  logic [31:0] ad_i,
  input  logic [3:0]  cbe_n_i,
  output logic [31:0] ad_o,
  output logic        ad_oe_o,
  output logic        trdy_n_o,
  output logic        stop_n_o,
  output logic        devsel_n_o,
  output logic        ctl_oe_o,
  output logic [31:0] be_addr_o,
  output logic [31:0] be_data_o,
  output logic [3:0]  be_ben_o,
  output logic        be_read_o,
  output logic        be_cfg_o,
  output logic        be_ack_n_o,
  input  logic        be_req_n_i,
  input  logic [31:0] be_rdata_i
);

  logic            io_start, io_rd, cfg_start, cfg_rd, hit;
  logic [AD_W-1:0] cfg_rdata;
  logic [5:0]      cfg_ofs;
  logic            cfg_wr_done;

  iop_decode u_decode (
    .frame_n_i   (frame_n_i),
    .idsel_i     (idsel_i),
    .cbe_n_i     (cbe_n_i),
    .ad_lo_i     (ad_i[1:0]),
    .io_start_o  (io_start),
    .io_rd_o     (io_rd),
    .cfg_start_o (cfg_start),
    .cfg_rd_o    (cfg_rd)
  );

  iop_window #(
    .WIN_BITS (WIN_BITS),
    .VEN_ID   (VEN_ID),
    .DEV_ID   (DEV_ID)
  ) u_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (be_addr_o),
    .ofs_i       (cfg_ofs),
    .wr_en_i     (cfg_wr_done),
    .wdata_i     (ad_i),
    .wben_n_i    (cbe_n_i),
    .hit_o       (hit),
    .cfg_rdata_o (cfg_rdata)
  );

  iop_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_n_i     (frame_n_i),
    .irdy_n_i      (irdy_n_i),
    .ad_i          (ad_i),
    .cbe_n_i       (cbe_n_i),
    .io_start_i    (io_start),
    .io_rd_i       (io_rd),
    .cfg_start_i   (cfg_start),
    .cfg_rd_i      (cfg_rd),
    .hit_i         (hit),
    .cfg_rdata_i   (cfg_rdata),
    .be_req_n_i    (be_req_n_i),
    .be_rdata_i    (be_rdata_i),
    .ad_o          (ad_o),
    .ad_oe_o       (ad_oe_o),
    .trdy_n_o      (trdy_n_o),
    .stop_n_o      (stop_n_o),
    .devsel_n_o    (devsel_n_o),
    .ctl_oe_o      (ctl_oe_o),
    .be_addr_o     (be_addr_o),
    .be_data_o     (be_data_o),
    .be_ben_o      (be_ben_o),
    .be_read_o     (be_read_o),
    .be_cfg_o      (be_cfg_o),
    .be_ack_n_o    (be_ack_n_o),
    .cfg_ofs_o     (cfg_ofs),
    .cfg_wr_done_o (cfg_wr_done)
  );

endmodule

// File: tb/iop_target_tb.sv
module iop_target_tb_top;

  localparam logic [15:0] VEN = 16'h5A17;
  localparam logic [15:0] DEV = 16'hC0DE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe = 4'hF;
  logic        req_n = 1'b1;
  logic [31:0] rdata = '0;

  logic [31:0] ad_o, be_addr, be_data;
  logic        ad_oe, trdy_n, stop_n, devsel_n, ctl_oe, be_read, be_cfg, ack_n;
  logic [3:0]  be_ben;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] bar_m = 32'h1;

  always #4 clk = ~clk;

  iop_target #(.WIN_BITS(8), .VEN_ID(VEN), .DEV_ID(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n), .irdy_n_i(irdy_n),
    .idsel_i(idsel), .ad_i(ad_in), .cbe_n_i(cbe), .ad_o(ad_o), .ad_oe_o(ad_oe),
    .trdy_n_o(trdy_n), .stop_n_o(stop_n), .devsel_n_o(devsel_n), .ctl_oe_o(ctl_oe),
    .be_addr_o(be_addr), .be_data_o(be_data), .be_ben_o(be_ben), .be_read_o(be_read),
    .be_cfg_o(be_cfg), .be_ack_n_o(ack_n), .be_req_n_i(req_n), .be_rdata_i(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_merge(input logic [31:0] old, input logic [31:0] wd,
                                            input logic [3:0] ben);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = ben[i/8] ? old[i] : wd[i];
    r[7:0] = 8'h01;
    return r;
  endfunction

  task automatic cfg_cycle(input logic [5:0] idx, input bit wr, input logic [31:0] wd,
                           input logic [3:0] ben, output logic [31:0] got);
    got = '0;
    @(negedge clk);
    frame_n = 0; idsel = 1; ad_in = {24'h0, idx, 2'b00}; cbe = wr ? 4'b1011 : 4'b1010; irdy_n = 1;
    @(negedge clk);
    chk("R8 cfg devsel", {31'h0, devsel_n}, 32'h0);
    chk("R8 cfg flag", {31'h0, be_cfg}, 32'h1);
    chk("R8 cfg trdy not yet", {31'h0, trdy_n}, 32'h1);
    frame_n = 1; idsel = 0; irdy_n = 0; ad_in = wd; cbe = ben;
    @(negedge clk);
    chk("R8 cfg trdy+stop", {30'h0, trdy_n, stop_n}, 32'h0);
    chk("R8 cfg no ack", {31'h0, ack_n}, 32'h1);
    chk("R11 cfg ad_oe", {31'h0, ad_oe}, {31'h0, !wr});
    got = ad_o;
    @(negedge clk);
    chk("R7 cfg release", {27'h0, ctl_oe, trdy_n, stop_n, devsel_n, be_cfg}, 32'h1E);
    irdy_n = 1; cbe = 4'hF;
    @(negedge clk);
    chk("R7 cfg oe off", {31'h0, ctl_oe}, 32'h0);
  endtask

  task automatic probe_unclaimed(input string req, input logic [31:0] addr,
                                 input logic [3:0] cmd, input bit sel);
    @(negedge clk);
    frame_n = 0; idsel = sel; ad_in = addr; cbe = cmd; irdy_n = 1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (c == 0) begin
        // address-like pattern mid-transaction must be ignored
        idsel = 0; irdy_n = 0; ad_in = bar_m & 32'hFFFF_FF00; cbe = 4'b0010;
      end
      chk(req, {28'h0, devsel_n, ack_n, be_cfg, ctl_oe}, 32'hC);
    end
    frame_n = 1; irdy_n = 1; cbe = 4'hF;
    @(negedge clk);
    @(negedge clk);
    chk(req, {28'h0, devsel_n, ack_n, be_cfg, ctl_oe}, 32'hC);
  endtask

  task automatic io_cycle(input logic [31:0] addr, input bit wr, input logic [31:0] wd,
                          input logic [3:0] ben, input bit burst, input int dly,
                          input logic [31:0] rd);
    bit hit;
    hit = (addr[31:8] == bar_m[31:8]);
    @(negedge clk);
    frame_n = 0; ad_in = addr; cbe = wr ? 4'b0011 : 4'b0010; irdy_n = 1;
    @(negedge clk);
    chk("R2 no devsel in compare", {31'h0, devsel_n}, 32'h1);
    frame_n = burst ? 1'b0 : 1'b1; irdy_n = 0; ad_in = wr ? wd : 32'hDEAD_BEEF; cbe = ben;
    @(negedge clk);
    if (!hit) begin
      for (int c = 0; c < 3; c++) begin
        chk("R3 miss no claim", {30'h0, devsel_n, ack_n}, 32'h3);
        @(negedge clk);
      end
      frame_n = 1; irdy_n = 1; cbe = 4'hF;
      @(negedge clk);
      return;
    end
    chk("R2 devsel on hit", {30'h0, devsel_n, ctl_oe}, 32'h1);
    @(negedge clk);
    chk("R4 ack", {31'h0, ack_n}, 32'h0);
    chk("R4 addr", be_addr, addr);
    chk("R4 dir+ben", {27'h0, be_read, be_ben}, {27'h0, !wr, ben});
    if (wr) chk("R4 wdata", be_data, wd);
    chk("R4 trdy waits", {31'h0, trdy_n}, 32'h1);
    for (int c = 0; c < dly; c++) begin
      @(negedge clk);
      chk("R4 trdy waits req", {31'h0, trdy_n}, 32'h1);
    end
    rdata = rd; req_n = 0;
    @(negedge clk);
    chk("R5 trdy+stop", {30'h0, trdy_n, stop_n}, 32'h0);
    chk("R11 ad_oe", {31'h0, ad_oe}, {31'h0, !wr});
    if (!wr) chk("R5 read data", ad_o, rd);
    req_n = 1;
    @(negedge clk);
    if (burst) begin
      chk("R6 holdoff", {27'h0, trdy_n, stop_n, devsel_n, ack_n, ad_oe}, 32'h12);
      irdy_n = 1;
      @(negedge clk);
      chk("R6 holdoff kept", {29'h0, trdy_n, stop_n, devsel_n}, 32'h4);
      frame_n = 1;
      @(negedge clk);
    end
    chk("R7 release", {27'h0, ctl_oe, trdy_n, stop_n, devsel_n, ack_n}, 32'h1F);
    irdy_n = 1; cbe = 4'hF;
    @(negedge clk);
    chk("R7 oe off", {31'h0, ctl_oe}, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic [31:0] hit_ofs [4] = '{32'h0, 32'h4, 32'h80, 32'hFC};
    logic [31:0] miss_a  [3] = '{32'h1234_5700, 32'h1234_55FC, 32'h9234_5600};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {25'h0, ctl_oe, ad_oe, trdy_n, stop_n, devsel_n, ack_n, be_cfg}, 32'h1E);
    rst_n = 1;
    @(negedge clk);
    cfg_cycle(6'd4, 0, 0, 0, got);
    chk("R1 base after reset", got, 32'h1);

    // R9 identity and unused registers
    cfg_cycle(6'd0, 0, 0, 0, got);
    chk("R9 id word", got, {DEV, VEN});
    cfg_cycle(6'd2, 0, 0, 0, got);
    chk("R9 unused reads zero", got, 32'h0);

    // R10 byte-enable sweep on the base register
    for (int b = 0; b < 16; b++) begin
      logic [31:0] wd;
      wd = {4{b[3:0], 4'(15 - b)}} ^ (32'h0101_0101 * b);
      cfg_cycle(6'd4, 1, wd, b[3:0], got);
      bar_m = exp_merge(bar_m, wd, b[3:0]);
      cfg_cycle(6'd4, 0, 0, 0, got);
      chk("R10 base merge", got, bar_m);
    end
    // R10 other index ignored
    cfg_cycle(6'd5, 1, 32'hFFFF_FFFF, 4'h0, got);
    cfg_cycle(6'd4, 0, 0, 0, got);
    chk("R10 other index ignored", got, bar_m);

    cfg_cycle(6'd4, 1, 32'h1234_5677, 4'h0, got);
    bar_m = exp_merge(bar_m, 32'h1234_5677, 4'h0);
    cfg_cycle(6'd4, 0, 0, 0, got);
    chk("R10 base set", got, 32'h1234_5601);

    // R8 / R3 unclaimed patterns
    probe_unclaimed("R8 cfg misaligned", 32'h0000_0011, 4'b1010, 1);
    probe_unclaimed("R8 cfg no idsel", 32'h0000_0010, 4'b1011, 0);
    probe_unclaimed("R3 memory cmd", 32'h1234_5600, 4'b0110, 0);

    // R2..R7 I/O sweep: hits and misses, both directions, burst attempts, req delays
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < 2; w++) begin
        io_cycle(32'h1234_5600 + hit_ofs[k], w[0], 32'hA5C3_0000 + 32'(k * 16 + w),
                 4'(k * 5 + w), ((k + w) % 2) == 1, (k + w) % 4,
                 32'h3C00_0000 ^ 32'(k * 257 + w));
      end
    end
    for (int k = 0; k < 3; k++) begin
      io_cycle(miss_a[k], 0, 0, 4'h0, k == 1, 0, 0);
      io_cycle(miss_a[k], 1, 32'h1, 4'h0, k != 1, 0, 0);
    end
    io_cycle(32'h1234_5610, 0, 0, 4'h3, 1, 2, 32'h0BAD_F00D);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule